// File: doc/BRIEF.md
# Registered-Feedback Burst Memory Slave

This block is a bus slave with synchronous termination in front of a small word-organised memory. The acknowledge and the read data come only from registers, so no combinational path leads from the master's request back to its termination input. To avoid the wait state that this would otherwise cost on every transfer, the slave decodes a 3-bit cycle-type tag and a 2-bit burst-type tag. From these it predicts the next beat. It keeps the acknowledge high back-to-back and prefetches the next read word while the current beat completes.

A master uses the block like any memory slave with byte selects. Single accesses cost two clocks each. A constant-address or incrementing burst of N beats costs N+1 clocks. The incrementing burst may be linear or may wrap in aligned groups of 4, 8 or 16 words. The byte address is converted to a word index by dropping the byte-offset bits. The memory depth follows from the address and data widths.

Top module: `rfb_mem_slave`

## Requirements
- R1: After reset, ack_o is 0 and dat_o is all zeros, and every memory word reads as zero.
- R2: Cycle-type code 000 (classic), code 111 (end-of-burst) used on a single access, and the reserved codes 011, 100, 101 and 110 are all served as a classic cycle. In such a cycle ack_o is high for one clock and then low, so each transfer takes two clocks, and a request with cyc_i and stb_i high while ack_o is low raises ack_o on the next clock.
- R3: For a beat that completes with code 001 (constant-address) or 010 (incrementing), ack_o stays high in the next clock, and dat_o then already holds the next beat's read word. A burst of N beats with no wait states completes in N+1 clocks.
- R4: A beat completes only in a clock where cyc_i, stb_i and ack_o are all high. A clock with ack_o high and stb_i low transfers nothing and writes nothing. With both ack_o and stb_i low, ack_o stays low.
- R5: While ack_o is held and stb_i is low, ack_o and dat_o stay unchanged until a beat completes.
- R6: When a beat completes with code 111, ack_o is low in the next clock.
- R7: For code 010 the burst-type code selects the next word: 00 is word+1 modulo the depth. Codes 01, 10 and 11 wrap within aligned groups of 4, 8 and 16 words. In a wrapped burst the low bits count modulo the group size, and after each full group the burst moves on to the next aligned group. For example, wrap-4 from word 1 visits 1,2,3,0,5,6,7,4.
- R8: For code 001 every beat of the burst reads or writes the same word.
- R9: The word index is adr_i shifted right by log2(DW/8). The byte-offset bits are ignored, so the per-beat address step is DW/8 bytes.
- R10: On a write beat, byte lane k (bits 8k+7 to 8k) of the word is updated only when sel_i[k] is 1. Other lanes keep their contents.
- R11: A clock with cyc_i low makes ack_o low in the next clock and clears the burst tracking, so the next request is served from its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Transfer request for this clock |
| we_i | input | 1 | 1 for write, 0 for read |
| adr_i | input | AW | Byte address |
| sel_i | input | DW/8 | Byte lane selects |
| cti_i | input | 3 | Cycle-type tag |
| bte_i | input | 2 | Burst-type tag for incrementing bursts |
| dat_i | input | DW | Write data |
| dat_o | output | DW | Registered read data |
| ack_o | output | 1 | Registered acknowledge |

## Verification
First the whole memory is filled with distinct words by a linear write burst. After that, every read beat shows which word the slave actually prefetched. This makes the wrap-4, wrap-8, wrap-16, linear-rollover and constant-address orderings distinguishable from one another. Classic, reserved and single end-of-burst accesses are timed against two clocks per transfer, and bursts against N+1 clocks. This separates a slave that predicts correctly from one that falls back to classic timing. Random mixes of tags, lengths, byte selects and master wait states then test the hold behaviour during wait states and masked byte writes. A burst abandoned by dropping cyc_i checks that the burst tracking is cleared.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
   localparam logic [2:0] CT_CLASSIC = 3'b000;
   localparam logic [2:0] CT_CONST   = 3'b001;
   localparam logic [2:0] CT_INCR    = 3'b010;
   localparam logic [2:0] CT_EOB     = 3'b111;

   localparam logic [1:0] BT_LINEAR  = 2'b00;
   localparam logic [1:0] BT_WRAP4   = 2'b01;
   localparam logic [1:0] BT_WRAP8   = 2'b10;
   localparam logic [1:0] BT_WRAP16  = 2'b11;
endpackage

// File: rtl/rfb_next_addr.sv
module rfb_next_addr
   import rfb_pkg::*;
#(
   parameter int WAW = 6
)(
   input  logic [WAW-1:0] cur,
   input  logic           incr,
   input  logic [1:0]     bte,
   input  logic           grp_end,
   output logic [WAW-1:0] nxt
);
   logic [WAW-1:0] low_mask;
   logic [WAW-1:0] grp_step;
   logic [WAW-1:0] plus1;

   always_comb begin
      unique case (bte)
         BT_WRAP4:  begin low_mask = WAW'(3);  grp_step = WAW'(4);  end
         BT_WRAP8:  begin low_mask = WAW'(7);  grp_step = WAW'(8);  end
         BT_WRAP16: begin low_mask = WAW'(15); grp_step = WAW'(16); end
         default:   begin low_mask = '1;       grp_step = '0;       end
      endcase
   end

   assign plus1 = cur + WAW'(1);

   always_comb begin
      if (!incr)
         nxt = cur;
      else
         nxt = ((cur & ~low_mask) + (grp_end ? grp_step : '0)) | (plus1 & low_mask);
   end

   // R7 / R8: an incrementing step always moves, a constant step never does
   always_comb begin
      if (incr)
         p_incr_moves_r7: assert (nxt != cur) else $error("next word equals current on increment");
      else
         p_const_stays_r8: assert (nxt == cur) else $error("constant burst changed word");
   end
endmodule

// File: rtl/rfb_mem.sv
module rfb_mem #(
   parameter int DW    = 32,
   parameter int DEPTH = 64
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [DW/8-1:0]        wr_sel,
   input  logic [$clog2(DEPTH)-1:0] wr_idx,
   input  logic [DW-1:0]          wr_data,
   input  logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic [DW-1:0]          rd_data
);
   localparam int NL = DW / 8;

   for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [7:0] lane_q [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) lane_q[i] <= '0;
         end else if (wr_en && wr_sel[l]) begin
            lane_q[wr_idx] <= wr_data[8*l +: 8];
         end
      end

      assign rd_data[8*l +: 8] = lane_q[rd_idx];
   end
endmodule

// File: rtl/rfb_mem_slave.sv
module rfb_mem_slave
   import rfb_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 8
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cyc_i,
   input  logic            stb_i,
   input  logic            we_i,
   input  logic [AW-1:0]   adr_i,
   input  logic [DW/8-1:0] sel_i,
   input  logic [2:0]      cti_i,
   input  logic [1:0]      bte_i,
   input  logic [DW-1:0]   dat_i,
   output logic [DW-1:0]   dat_o,
   output logic            ack_o
);
   localparam int NL    = DW / 8;
   localparam int LSB   = $clog2(NL);
   localparam int WAW   = AW - LSB;
   localparam int DEPTH = 1 << WAW;

   if ((DW % 8) != 0 || (NL & (NL - 1)) != 0) begin : g_bad_dw
      $error("rfb_mem_slave: DW must be 8 times a power of two");
   end
   if (WAW < 4 || WAW > 12) begin : g_bad_aw
      $error("rfb_mem_slave: word address width must be 4 to 12 bits");
   end
   if (LSB > 0) begin : g_low
      logic unused_low;
      assign unused_low = ^adr_i[LSB-1:0];
   end

   logic [WAW-1:0] req_w, nxt_w, rd_w;
   logic [DW-1:0]  rd_data;
   logic           ack_q;
   logic [DW-1:0]  dat_q;
   logic [3:0]     beat_cnt;
   logic [3:0]     cnt_mask;
   logic           beat_done, start_req, keep_going, grp_end;

   assign req_w      = adr_i[AW-1:LSB];
   assign beat_done  = cyc_i & stb_i & ack_q;
   assign start_req  = cyc_i & stb_i & ~ack_q;
   assign keep_going = (cti_i == CT_CONST) || (cti_i == CT_INCR);

   always_comb begin
      unique case (bte_i)
         BT_WRAP4:  cnt_mask = 4'd3;
         BT_WRAP8:  cnt_mask = 4'd7;
         default:   cnt_mask = 4'd15;
      endcase
   end
   assign grp_end = (bte_i != BT_LINEAR) && ((beat_cnt & cnt_mask) == cnt_mask);

   rfb_next_addr #(.WAW(WAW)) u_next (
      .cur     (req_w),
      .incr    (cti_i == CT_INCR),
      .bte     (bte_i),
      .grp_end (grp_end),
      .nxt     (nxt_w)
   );

   assign rd_w = beat_done ? nxt_w : req_w;

   rfb_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (beat_done & we_i),
      .wr_sel  (sel_i),
      .wr_idx  (req_w),
      .wr_data (dat_i),
      .rd_idx  (rd_w),
      .rd_data (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q    <= 1'b0;
         dat_q    <= '0;
         beat_cnt <= '0;
      end else if (!cyc_i) begin
         ack_q    <= 1'b0;
         beat_cnt <= '0;
      end else if (beat_done) begin
         ack_q    <= keep_going;
         beat_cnt <= keep_going ? beat_cnt + 4'd1 : 4'd0;
         if (keep_going) dat_q <= rd_data;
      end else if (start_req) begin
         ack_q    <= 1'b1;
         beat_cnt <= '0;
         dat_q    <= rd_data;
      end
   end

   assign ack_o = ack_q;
   assign dat_o = dat_q;

   p_req_acked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_i && stb_i && !ack_o |=> ack_o) else $error("request not acknowledged");
   p_classic_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_i && stb_i && ack_o && !(cti_i == CT_CONST || cti_i == CT_INCR) |=> !ack_o)
      else $error("classic beat kept ack");
   p_burst_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_i && stb_i && ack_o && (cti_i == CT_CONST || cti_i == CT_INCR) |=> ack_o)
      else $error("burst beat dropped ack");
   p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_o && !stb_i |=> !ack_o) else $error("ack without request");
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_i && ack_o && !stb_i |=> ack_o && $stable(dat_o)) else $error("held beat changed");
   p_eob_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_i && stb_i && ack_o && cti_i == CT_EOB |=> !ack_o) else $error("ack kept after end of burst");
   p_idle_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_i |=> !ack_o) else $error("ack while no cycle");
endmodule

// File: tb/sim_rfb_mem_slave.sv
`timescale 1ns/1ps
module sim_rfb_mem_slave;
   import rfb_pkg::*;
   localparam int DW    = 32;
   localparam int AW    = 8;
   localparam int NL    = DW / 8;
   localparam int LSB   = $clog2(NL);
   localparam int DEPTH = 1 << (AW - LSB);

   logic clk = 1'b0, rst_n = 1'b0, cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [AW-1:0] adr = '0;
   logic [NL-1:0] sel = '0;
   logic [2:0]    cti = '0;
   logic [1:0]    bte = '0;
   logic [DW-1:0] wdat = '0;
   logic [DW-1:0] rdat;
   logic          ack;
   int n_chk = 0, n_err = 0;
   logic [DW-1:0] model [DEPTH];

   always #2.5 clk = ~clk;

   rfb_mem_slave #(.DW(DW), .AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we), .adr_i(adr),
      .sel_i(sel), .cti_i(cti), .bte_i(bte), .dat_i(wdat), .dat_o(rdat), .ack_o(ack)
   );

   task automatic check(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic bit is_burst(logic [2:0] k);
      return (k == CT_CONST) || (k == CT_INCR);
   endfunction

   // expected next word after beat index 'idx' completed at word w
   function automatic int next_w(int w, logic [2:0] kind, logic [1:0] b, int idx);
      int m, up;
      if (kind == CT_CONST) return w;
      if (kind != CT_INCR || b == 2'b00) return (w + 1) % DEPTH;
      m = (b == 2'b01) ? 3 : (b == 2'b10) ? 7 : 15;
      up = w & ~m;
      if ((idx & m) == m) up = (up + m + 1) % DEPTH;
      return up | ((w + 1) & m);
   endfunction

   task automatic drive_beat(input int w, input int beat, input int n, input logic [2:0] kind);
      adr  = AW'((w << LSB) | int'($urandom % NL));
      cti  = (is_burst(kind) && beat == n - 1) ? CT_EOB : kind;
      wdat = $urandom;
      stb  = 1'b1;
   endtask

   task automatic run_burst(input bit wr, input logic [2:0] kind, input logic [1:0] b,
                            input int start_w, input int n, input int max_wait,
                            input logic [NL-1:0] s, input string rq);
      int w = start_w;
      int beat = 0;
      int cycles = 0;
      int k, exp_cyc;
      cyc = 1'b1; we = wr; bte = b;
      sel = (s != '0) ? s : NL'($urandom);
      if (sel == '0) sel[0] = 1'b1;
      drive_beat(w, beat, n, kind);
      while (beat < n && cycles < 2000) begin
         if (stb && ack) begin
            if (!wr) check(rdat == model[w], rq, rdat, model[w]);
            else for (int l = 0; l < NL; l++) if (sel[l]) model[w][8*l +: 8] = wdat[8*l +: 8];
            beat++;
            @(posedge clk); cycles++; @(negedge clk);
            if (beat < n) begin
               w = next_w(w, kind, b, beat - 1);
               k = (is_burst(kind) && max_wait > 0) ? int'($urandom % (max_wait + 1)) : 0;
               for (int i = 0; i < k; i++) begin
                  stb = 1'b0; wdat = $urandom;
                  check(ack == 1'b1, "R5 ack held in master wait", DW'(ack), DW'(1));
                  if (!wr) check(rdat == model[w], "R5 prefetched word held", rdat, model[w]);
                  @(posedge clk); cycles++; @(negedge clk);
               end
               drive_beat(w, beat, n, kind);
            end
         end else begin
            @(posedge clk); cycles++; @(negedge clk);
         end
      end
      if (max_wait == 0) begin
         exp_cyc = is_burst(kind) ? n + 1 : 2 * n;
         check(cycles == exp_cyc, is_burst(kind) ? "R3 burst clock count" : "R2 classic clock count",
               DW'(cycles), DW'(exp_cyc));
      end
      check(ack == 1'b0, is_burst(kind) ? "R6 ack low after last beat" : "R2 ack low after transfer",
            DW'(ack), DW'(0));
      cyc = 1'b0; stb = 1'b0; we = 1'b0; cti = CT_CLASSIC;
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [2:0] kind;
      void'($urandom(32'd4242));
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      check(ack == 1'b0, "R1 reset ack", DW'(ack), DW'(0));
      check(rdat == '0, "R1 reset data", rdat, '0);
      rst_n = 1'b1;
      @(negedge clk);
      run_burst(1'b0, CT_CLASSIC, 2'b00, 9, 2, 0, '0, "R1 memory zero after reset");
      // fill all words with distinct data
      run_burst(1'b1, CT_INCR, BT_LINEAR, 0, DEPTH, 0, '1, "R3 linear write fill");
      run_burst(1'b0, CT_INCR, BT_WRAP4, 1, 8, 0, '0, "R7 wrap-4 read from word 1");
      run_burst(1'b0, CT_INCR, BT_WRAP8, 13, 16, 0, '0, "R7 wrap-8 read");
      run_burst(1'b0, CT_INCR, BT_WRAP16, 37, 17, 0, '0, "R7 wrap-16 read");
      run_burst(1'b0, CT_INCR, BT_LINEAR, 60, 8, 0, '0, "R7 linear rollover read, R9 byte offset ignored");
      run_burst(1'b1, CT_CONST, 2'b00, 10, 6, 3, '0, "R8 R10 R4 constant write with waits");
      run_burst(1'b0, CT_CONST, 2'b00, 10, 3, 0, '0, "R8 R10 R4 constant read back");
      run_burst(1'b0, CT_CLASSIC, 2'b00, 20, 4, 0, '0, "R2 classic reads");
      run_burst(1'b0, 3'b101, 2'b00, 30, 3, 0, '0, "R2 reserved code as classic");
      run_burst(1'b1, CT_EOB, 2'b00, 40, 2, 0, '0, "R2 R6 single end-of-burst writes");
      run_burst(1'b0, CT_EOB, 2'b00, 40, 2, 0, '0, "R2 R6 single end-of-burst reads");
      // R11: abandon a burst by dropping cyc
      cyc = 1'b1; we = 1'b0; bte = BT_LINEAR; sel = '1;
      adr = AW'(5 << LSB); cti = CT_INCR; stb = 1'b1;
      @(posedge clk); @(negedge clk);
      check(ack == 1'b1, "R11 burst started", DW'(ack), DW'(1));
      @(posedge clk); @(negedge clk);
      check(ack == 1'b1, "R11 burst ack held", DW'(ack), DW'(1));
      cyc = 1'b0; stb = 1'b0;
      @(posedge clk); @(negedge clk);
      check(ack == 1'b0, "R11 ack cleared after cyc low", DW'(ack), DW'(0));
      run_burst(1'b0, CT_CLASSIC, 2'b00, 50, 1, 0, '0, "R11 fresh request after abandon");
      // random mix
      for (int it = 0; it < 40; it++) begin
         case ($urandom % 6)
            0: kind = CT_CLASSIC;
            1: kind = CT_CONST;
            2, 3: kind = CT_INCR;
            4: kind = CT_EOB;
            default: kind = 3'(3 + $urandom % 4);
         endcase
         run_burst(1'($urandom), kind, 2'($urandom), int'($urandom % DEPTH),
                   1 + int'($urandom % 10), int'($urandom % 3), '0, "R3 R4 R5 R7 R10 random mix");
      end
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule